// File: doc/BRIEF.md
# Wide Free-Running Timestamp Counter

This block is a system time base: a wide up-counter that advances by one on every cycle in which a tick-enable input is high, provided counting has been switched on. Software reaches it through two 32-bit registers. The low word carries the least significant part of the count. The high word carries the remaining top bits together with a run-control bit. The block has no interrupt output, and the count rolls over silently.

Software takes a full reading by reading the low word first and the high word second. A low-word read copies the top count bits into a shadow register. The high-word read that follows returns that copy, so the two halves belong to the same instant even when a carry ripples into the top bits between the two reads. Writing the run bit to one starts counting from the held value. Writing it to zero stops the counter and clears it. Count bits cannot be written.

The counter core runs a two-state run-control machine. The states are CNT_OFF and CNT_RUN. Transition START goes from CNT_OFF to CNT_RUN on a high-word write with the run bit set. Transition HALT goes from CNT_RUN to CNT_OFF on a high-word write with the run bit clear. The read port runs a two-state pairing machine. The states are RD_LIVE, where a high read returns live top bits, and RD_HELD, where a high read returns the shadow. Transition LATCH is taken on any low read and leads to RD_HELD, or stays there and refreshes the shadow. Transition RELEASE is taken on a high read and leads from RD_HELD back to RD_LIVE.

Top module: `tsc_timestamp`

## Requirements
- R1: After reset the count is zero, the run bit is zero, and bus_rvalid and bus_rdata are zero.
- R2: In state CNT_RUN the count increases by exactly one on each clock edge where tick is high. Tick has no effect in CNT_OFF, where the count holds.
- R3: A read (bus_sel=1, bus_wr=0) at byte offset 0x0 returns the count bits [LO_W-1:0], zero-extended to 32 bits. The data appears with bus_rvalid=1 one cycle after the request, and it is the count as it stood before that clock edge. bus_rvalid is 0 in every cycle that does not follow a read.
- R4: A read at byte offset 0x4 returns the top CNT_W-LO_W count bits in bits [CNT_W-LO_W-1:0] and the run bit in bit 8. All other bits read as zero.
- R5: After a low read, the next high read returns the top bits as they were at that low read, even if the count has carried since. Low reads in between refresh the copy. That high read releases the copy, so later high reads return live top bits.
- R6: A write at offset 0x4 with bit 8 set starts counting from the held count. A write with bit 8 clear stops the counter and clears the count to zero on that edge.
- R7: Writes at offset 0x0 are ignored. Bits of a high-word write other than bit 8 are ignored.
- R8: From all ones the count wraps to zero on the next counted tick, and counting continues with no other effect.
- R9: Reads at any offset other than 0x0 and 0x4 return zero, and writes there are ignored.
- R10: A clearing high-word write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse from the reference rate |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset (0x0 low word, 0x4 high word) |
| bus_wdata | input | 32 | Write data (only bit 8 of a high-word write is used) |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | One-cycle pulse one cycle after a read request |

## Verification
The assertions assume that tick, bus_sel, bus_wr, bus_addr and bus_wdata are stable, known values at every rising edge. They also assume that the parameters keep the top part between one and eight bits, so that it never collides with the run bit. The bench drives every input for exactly one cycle on the falling edge, so each rising edge samples settled values. It runs the block with a 12-bit count split 8 + 4. With that split, the carry into the top bits and the full wrap are reachable in a few thousand ticks. The bench places reads in the very cycle a carry happens, to test the shadow pairing.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int BUS_W  = 32;  // register word width
    localparam int EN_POS = 8;   // run-control bit in the high word

    typedef enum logic {
        CNT_OFF,
        CNT_RUN
    } cnt_state_e;

    typedef enum logic {
        RD_LIVE,
        RD_HELD
    } rd_state_e;

endpackage

// File: rtl/tsc_core.sv
module tsc_core
    import tsc_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_ctl,   // high-word write strobe
    input  logic             ctl_en,   // run bit carried by that write
    output logic [CNT_W-1:0] cnt_q,
    output logic             run
);

    cnt_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_OFF;
        else        state_q <= state_nx;
    end

    // transitions START / HALT
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CNT_OFF: if (wr_ctl && ctl_en)  state_nx = CNT_RUN;
            CNT_RUN: if (wr_ctl && !ctl_en) state_nx = CNT_OFF;
        endcase
    end

    // outputs: count register and run flag
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (wr_ctl && !ctl_en)         cnt_q <= '0;
        else if (state_q == CNT_RUN && tick) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign run = (state_q == CNT_RUN);

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wr_ctl) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_ctl) |=> $stable(cnt_q));

    a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_en) |=> run);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !ctl_en) |=> (cnt_q == '0 && !run));

    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wr_ctl && cnt_q == '1) |=> cnt_q == '0);

endmodule

// File: rtl/tsc_readport.sv
module tsc_readport
    import tsc_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int LO_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_any,
    input  logic             rd_lo,
    input  logic             rd_hi,
    input  logic [CNT_W-1:0] cnt,
    input  logic             run,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid
);

    localparam int HI_W = CNT_W - LO_W;  // must lie in 1..EN_POS

    rd_state_e         state_q, state_nx;
    logic [HI_W-1:0]   shadow_q;
    logic [HI_W-1:0]   hi_sel;
    logic [BUS_W-1:0]  lo_word, hi_word;

    // state register plus shadow copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RD_LIVE;
            shadow_q <= '0;
        end else begin
            state_q <= state_nx;
            if (rd_lo) shadow_q <= cnt[CNT_W-1:LO_W];
        end
    end

    // transitions LATCH / RELEASE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RD_LIVE: if (rd_lo) state_nx = RD_HELD;
            RD_HELD: if (rd_hi) state_nx = RD_LIVE;
        endcase
    end

    always_comb begin
        hi_sel          = (state_q == RD_HELD) ? shadow_q : cnt[CNT_W-1:LO_W];
        lo_word         = BUS_W'(cnt[LO_W-1:0]);
        hi_word         = '0;
        hi_word[HI_W-1:0] = hi_sel;
        hi_word[EN_POS] = run;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_any;
            if (rd_lo)       rdata <= lo_word;
            else if (rd_hi)  rdata <= hi_word;
            else             rdata <= '0;
        end
    end

    a_r3_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> rvalid);

    a_r3_novalid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !rvalid);

    a_r3_low_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> rdata == BUS_W'($past(cnt[LO_W-1:0])));

    a_r4_run_bit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> rdata[EN_POS] == $past(run));

    a_r5_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo ##1 rd_hi) |=> rdata[HI_W-1:0] == $past(cnt[CNT_W-1:LO_W], 2));

    a_r9_other: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !rd_lo && !rd_hi) |=> rdata == '0);

endmodule

// File: rtl/tsc_timestamp.sv
module tsc_timestamp
    import tsc_pkg::*;
#(
    parameter int CNT_W  = 40,
    parameter int LO_W   = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid
);

    logic              hit_lo, hit_hi;
    logic              rd_any, rd_lo, rd_hi, wr_ctl;
    logic [CNT_W-1:0]  cnt;
    logic              run;
    logic              unused_wdata;

    assign hit_lo = (bus_addr == ADDR_W'(0));
    assign hit_hi = (bus_addr == ADDR_W'(4));
    assign rd_any = bus_sel && !bus_wr;
    assign rd_lo  = rd_any && hit_lo;
    assign rd_hi  = rd_any && hit_hi;
    assign wr_ctl = bus_sel && bus_wr && hit_hi;
    assign unused_wdata = ^bus_wdata;

    tsc_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr_ctl (wr_ctl),
        .ctl_en (bus_wdata[EN_POS]),
        .cnt_q  (cnt),
        .run    (run)
    );

    tsc_readport #(.CNT_W(CNT_W), .LO_W(LO_W)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_any (rd_any),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .cnt    (cnt),
        .run    (run),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

endmodule

// File: tb/tsc_timestamp_test.sv
module tsc_timestamp_test;

    localparam int CNT_W = 12;
    localparam int LO_W  = 8;
    localparam int HI_W  = CNT_W - LO_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int compared = 0;
    int mismatched = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // bench-side model
    logic [CNT_W-1:0] m_cnt = '0;
    logic             m_en = 1'b0;
    logic [HI_W-1:0]  m_sh = '0;
    logic             m_held = 1'b0;

    tsc_timestamp #(.CNT_W(CNT_W), .LO_W(LO_W), .ADDR_W(3)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // one bus cycle; driver pushes expected read data into the scoreboard
    task automatic op(input string tag, input logic t, input logic s, input logic w,
                      input logic [2:0] a, input logic [31:0] d);
        logic [31:0] e;
        @(negedge clk);
        tick = t; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        if (s && !w) begin
            e = '0;
            if (a == 3'd0) begin
                e = 32'(m_cnt[LO_W-1:0]);
                m_sh = m_cnt[CNT_W-1:LO_W];
                m_held = 1'b1;
            end else if (a == 3'd4) begin
                e[HI_W-1:0] = m_held ? m_sh : m_cnt[CNT_W-1:LO_W];
                e[8] = m_en;
                m_held = 1'b0;
            end
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end
        if (s && w && a == 3'd4 && !d[8]) begin
            m_en = 1'b0;
            m_cnt = '0;
        end else begin
            if (m_en && t) m_cnt = m_cnt + CNT_W'(1);
            if (s && w && a == 3'd4) m_en = 1'b1;
        end
        @(posedge clk);
    endtask

    task automatic idle(input string tag, input logic t);
        op(tag, t, 1'b0, 1'b0, 3'd0, 32'h0);
    endtask

    // monitor: pop and compare as results appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 100000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rvalid in reset", 32'(bus_rvalid), 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;

        op("R1 low after reset", 0, 1, 0, 3'd0, 0);
        op("R1 high after reset", 0, 1, 0, 3'd4, 0);

        // R2: ticks while stopped do nothing
        for (int i = 0; i < 5; i++) idle("R2", 1);
        op("R2 held while off", 0, 1, 0, 3'd0, 0);

        // R6: start, with a tick in the same cycle (not counted)
        op("R6 start", 1, 1, 1, 3'd4, 32'h100);
        for (int i = 0; i < 14; i++) idle("R2", (i % 3) != 0);
        op("R2 R3 count after gapped ticks", 0, 1, 0, 3'd0, 0);
        op("R4 high word running", 0, 1, 0, 3'd4, 0);

        // R7: ignored writes
        op("R7", 1, 1, 1, 3'd0, 32'hFFFF_FFFF);
        op("R7", 1, 1, 1, 3'd4, 32'hFFFF_FFFF);
        op("R7 low after ignored writes", 0, 1, 0, 3'd0, 0);
        op("R7 high after ignored writes", 0, 1, 0, 3'd4, 0);

        // R5: low read in the cycle of a carry into the top bits
        while (m_cnt[LO_W-1:0] != '1) idle("R5", 1);
        op("R5 low read at carry", 1, 1, 0, 3'd0, 0);
        op("R5 paired high read", 1, 1, 0, 3'd4, 0);
        op("R5 released high read", 0, 1, 0, 3'd4, 0);
        op("R5 low read", 1, 1, 0, 3'd0, 0);
        op("R5 refreshed low read", 1, 1, 0, 3'd0, 0);
        op("R5 high after double low", 0, 1, 0, 3'd4, 0);

        // R9: other offsets
        op("R9", 1, 1, 1, 3'd2, 32'h0);
        op("R9 offset 0x2 reads zero", 0, 1, 0, 3'd2, 0);
        op("R9 offset 0x7 reads zero", 0, 1, 0, 3'd7, 0);
        op("R9 count unaffected", 0, 1, 0, 3'd0, 0);

        // R10: clear beats tick
        op("R10 clear with tick", 1, 1, 1, 3'd4, 32'h0);
        op("R10 low after clear", 1, 1, 0, 3'd0, 0);
        op("R6 high after clear", 0, 1, 0, 3'd4, 0);

        // R8: run to all ones and wrap
        op("R8 restart", 0, 1, 1, 3'd4, 32'h100);
        while (m_cnt != '1) idle("R8", 1);
        op("R8 low at all ones", 0, 1, 0, 3'd0, 0);
        op("R8 high at all ones", 0, 1, 0, 3'd4, 0);
        idle("R8", 1);
        op("R8 low after wrap", 0, 1, 0, 3'd0, 0);
        op("R8 high after wrap", 0, 1, 0, 3'd4, 0);
        idle("R8", 1);
        op("R8 counts on after wrap", 0, 1, 0, 3'd0, 0);

        idle("end", 0);
        idle("end", 0);
        check("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finish_run();
    end

endmodule